// File: doc/BRIEF.md
# Banked Operand Collection Queue

This block sits between the issue stage and a vector execution unit. Each issued instruction carries a tag and up to three source register indices. The instruction waits in a small in-order queue while its source words are fetched from a register file that is split into four banks, each with a single read port. Instructions leave the queue in the order they arrived, through a valid/ready dispatch port. Each word of the dispatched operand bundle holds the value read for one source slot.

Every cycle, each bank looks at all resident instructions and grants its port to the oldest one that still needs a word from that bank. A bank that the older instructions do not need goes to a younger instruction. This way a conflict on one instruction does not leave the other banks idle. Read data comes back one cycle after the request and is stored in the slot that was chosen when the grant was made.

Top module: `opnd_collect_buf`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1, `dsp_valid` is 0 and no bank request is raised.
- R2: A source with register index i is read through bank (i mod 4), the low two bits of i. `rd_addr` for that bank carries the full index.
- R3: Each bank raises at most one request per cycle. Only instructions already resident make requests, starting in the cycle after the instruction is accepted.
- R4: For each bank, the oldest resident instruction with a pending source in that bank wins. Within one instruction, the lowest source position goes first.
- R5: A bank with no pending source in any older instruction is granted in the same cycle to a younger instruction that has a pending source in it.
- R6: The word on a bank's `rd_data` in the cycle after its request is stored as the operand of the granted source. It appears in that source's word of `dsp_opnd` (source k at bits k*32 upward).
- R7: A source whose `iss_use` bit is 0 needs no read and counts as fetched. It is dispatched as zero.
- R8: Instructions are dispatched strictly in issue order. `dsp_valid` rises in the cycle after the oldest instruction's last operand word is stored. While `dsp_ready` is low, the tag and operands hold.
- R9: With four instructions resident, `iss_ready` is low unless the oldest one dispatches in the same cycle, in which case a new one is accepted in that cycle. An issue offered while not ready is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue offer |
| iss_ready | output | 1 | Queue can accept an issue |
| iss_tag | input | 8 | Instruction tag |
| iss_use | input | 3 | Per-source used flags |
| iss_idx | input | 24 | Three source register indices, source k at bits k*8 upward |
| rd_req | output | 4 | Per-bank read request |
| rd_addr | output | 32 | Per-bank register index, bank b at bits b*8 upward |
| rd_data | input | 128 | Per-bank read word, valid one cycle after the request |
| dsp_valid | output | 1 | Oldest instruction has all operands |
| dsp_ready | input | 1 | Execution unit accepts |
| dsp_tag | output | 8 | Tag of the dispatched instruction |
| dsp_opnd | output | 96 | Three operand words, source k at bits k*32 upward |

## Verification
The bench builds the block with the default parameters: a depth of four, four banks, three sources, 8-bit indices, 32-bit words and 8-bit tags. With a depth of only four, a few cycles of withheld `dsp_ready` fill the queue, so the full-queue stall, the dropped issue and the combined issue-and-dispatch all come up in a short run. With four banks, indices that are multiples of four collide on one port, so the bench can count the exact grant order of an oldest-first contest next to a younger instruction that uses a free bank.

// File: rtl/opnd_collect_buf.sv
module opnd_collect_buf #(
  parameter int DEPTH  = 4,
  parameter int NBANK  = 4,
  parameter int NSRC   = 3,
  parameter int REG_W  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  output logic                    iss_ready,
  input  logic [TAG_W-1:0]        iss_tag,
  input  logic [NSRC-1:0]         iss_use,
  input  logic [NSRC*REG_W-1:0]   iss_idx,
  output logic [NBANK-1:0]        rd_req,
  output logic [NBANK*REG_W-1:0]  rd_addr,
  input  logic [NBANK*DATA_W-1:0] rd_data,
  output logic                    dsp_valid,
  input  logic                    dsp_ready,
  output logic [TAG_W-1:0]        dsp_tag,
  output logic [NSRC*DATA_W-1:0]  dsp_opnd
);
  localparam int PW = $clog2(DEPTH);
  localparam int BW = $clog2(NBANK);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [DEPTH-1:0]  live;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [NSRC-1:0]   done_q [DEPTH];
  logic [NSRC-1:0]   busy_q [DEPTH];
  logic [REG_W-1:0]  idx_q  [DEPTH][NSRC];
  logic [DATA_W-1:0] opd_q  [DEPTH][NSRC];
  logic [PW-1:0]     head, tail;

  logic [NBANK-1:0]  ret_v;
  logic [PW-1:0]     ret_slot [NBANK];
  logic [SW-1:0]     ret_src  [NBANK];

  logic [NBANK-1:0]  gnt;
  logic [PW-1:0]     gnt_slot [NBANK];
  logic [SW-1:0]     gnt_src  [NBANK];
  logic [PW-1:0]     age_slot [DEPTH];

  logic dsp_fire, iss_fire;

  for (genvar a = 0; a < DEPTH; a++) begin : g_age
    assign age_slot[a] = head + PW'(a);
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < NBANK; b++) begin
      gnt_slot[b] = '0;
      gnt_src[b]  = '0;
      for (int a = 0; a < DEPTH; a++) begin
        for (int k = 0; k < NSRC; k++) begin
          if (!gnt[b] && live[age_slot[a]] && !done_q[age_slot[a]][k] &&
              !busy_q[age_slot[a]][k] &&
              idx_q[age_slot[a]][k][BW-1:0] == BW'(b)) begin
            gnt[b]      = 1'b1;
            gnt_slot[b] = age_slot[a];
            gnt_src[b]  = SW'(k);
          end
        end
      end
    end
  end

  assign rd_req = gnt;
  for (genvar b = 0; b < NBANK; b++) begin : g_addr
    assign rd_addr[b*REG_W +: REG_W] = idx_q[gnt_slot[b]][gnt_src[b]];
  end

  assign dsp_valid = live[head] && (&done_q[head]);
  assign dsp_fire  = dsp_valid && dsp_ready;
  assign iss_ready = !live[tail] || dsp_fire;
  assign iss_fire  = iss_valid && iss_ready;
  assign dsp_tag   = tag_q[head];
  for (genvar k = 0; k < NSRC; k++) begin : g_opnd
    assign dsp_opnd[k*DATA_W +: DATA_W] = opd_q[head][k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      head  <= '0;
      tail  <= '0;
      ret_v <= '0;
      for (int b = 0; b < NBANK; b++) begin
        ret_slot[b] <= '0;
        ret_src[b]  <= '0;
      end
      for (int s = 0; s < DEPTH; s++) begin
        tag_q[s]  <= '0;
        done_q[s] <= '0;
        busy_q[s] <= '0;
        for (int k = 0; k < NSRC; k++) begin
          idx_q[s][k] <= '0;
          opd_q[s][k] <= '0;
        end
      end
    end else begin
      ret_v <= gnt;
      for (int b = 0; b < NBANK; b++) begin
        ret_slot[b] <= gnt_slot[b];
        ret_src[b]  <= gnt_src[b];
        if (gnt[b]) busy_q[gnt_slot[b]][gnt_src[b]] <= 1'b1;
        if (ret_v[b]) begin
          opd_q[ret_slot[b]][ret_src[b]]  <= rd_data[b*DATA_W +: DATA_W];
          done_q[ret_slot[b]][ret_src[b]] <= 1'b1;
          busy_q[ret_slot[b]][ret_src[b]] <= 1'b0;
        end
      end
      if (dsp_fire) begin
        live[head] <= 1'b0;
        head       <= head + PW'(1);
      end
      if (iss_fire) begin
        live[tail]   <= 1'b1;
        tag_q[tail]  <= iss_tag;
        done_q[tail] <= ~iss_use;
        busy_q[tail] <= '0;
        for (int k = 0; k < NSRC; k++) begin
          idx_q[tail][k] <= iss_idx[k*REG_W +: REG_W];
          opd_q[tail][k] <= '0;
        end
        tail <= tail + PW'(1);
      end
    end
  end

  // R9
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !(dsp_valid && dsp_ready)) |=>
      $countones(live) == $past($countones(live)) + 1);

  // R8
  dispatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_tag) && $stable(dsp_opnd)));

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R6
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_v[b] |-> (live[ret_slot[b]] && busy_q[ret_slot[b]][ret_src[b]] &&
                    !done_q[ret_slot[b]][ret_src[b]]));
    // R2
    bank_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[b] |-> (rd_addr[b*REG_W +: BW] == BW'(b)));
  end
endmodule

// File: tb/opnd_collect_buf_tb.sv
`timescale 1ns/1ps
module opnd_collect_buf_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         iss_valid;
  logic         iss_ready;
  logic [7:0]   iss_tag;
  logic [2:0]   iss_use;
  logic [23:0]  iss_idx;
  logic [3:0]   rd_req;
  logic [31:0]  rd_addr;
  logic [127:0] rd_data;
  logic         dsp_valid;
  logic         dsp_ready;
  logic [7:0]   dsp_tag;
  logic [95:0]  dsp_opnd;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opnd_collect_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .iss_use(iss_use), .iss_idx(iss_idx),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_tag(dsp_tag),
    .dsp_opnd(dsp_opnd)
  );

  function automatic logic [31:0] regval(input logic [7:0] a);
    return {8'hC0, a, ~a, a ^ 8'h3C};
  endfunction

  logic [3:0]  rq_q;
  logic [31:0] ra_q;
  always @(posedge clk) begin
    rq_q <= rd_req;
    ra_q <= rd_addr;
  end
  for (genvar b = 0; b < 4; b++) begin : g_rf
    assign rd_data[b*32 +: 32] = rq_q[b] ? regval(ra_q[b*8 +: 8]) : 32'hDEAD_BEEF;
  end

  // {tag, use, idx2, idx1, idx0}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {8'h10, 3'b111, 8'd8,   8'd4,   8'd0  },
    {8'h11, 3'b011, 8'd0,   8'd2,   8'd1  },
    {8'h12, 3'b000, 8'd5,   8'd6,   8'd7  },
    {8'h13, 3'b101, 8'd7,   8'd9,   8'd3  },
    {8'h14, 3'b111, 8'd7,   8'd6,   8'd5  },
    {8'h15, 3'b001, 8'd0,   8'd0,   8'd255},
    {8'h16, 3'b110, 8'd64,  8'd128, 8'd77 },
    {8'h17, 3'b111, 8'd9,   8'd9,   8'd9  },
    {8'h18, 3'b010, 8'd0,   8'd42,  8'd0  },
    {8'h19, 3'b111, 8'd14,  8'd13,  8'd12 },
    {8'h1A, 3'b100, 8'd200, 8'd0,   8'd0  },
    {8'h1B, 3'b111, 8'd10,  8'd6,   8'd2  }
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] t, input logic [2:0] u,
                       input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2);
    iss_valid = v;
    iss_tag   = t;
    iss_use   = u;
    iss_idx   = {i2, i1, i0};
  endtask

  task automatic chk_dsp(input string rq, input logic [7:0] t, input logic [2:0] u,
                         input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2);
    chk({rq, " tag"}, {24'd0, dsp_tag}, {24'd0, t});
    chk({rq, " op0"}, dsp_opnd[31:0],  u[0] ? regval(i0) : 32'd0);
    chk({rq, " op1"}, dsp_opnd[63:32], u[1] ? regval(i1) : 32'd0);
    chk({rq, " op2"}, dsp_opnd[95:64], u[2] ? regval(i2) : 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  ti;
    int  ri;
    bit  fire_i;
    rst_n = 1'b0;
    dsp_ready = 1'b0;
    drive(1'b0, 8'h00, 3'b000, 8'd0, 8'd0, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 iss_ready", {31'd0, iss_ready}, 32'd1);
    chk("R1 dsp_valid", {31'd0, dsp_valid}, 32'd0);
    chk("R1 rd_req",    {28'd0, rd_req},    32'd0);

    // table walk: R6 R7 R8 under varied patterns
    ti = 0; ri = 0; fire_i = 1'b0;
    for (int cyc = 0; cyc < 2000 && ri < NV; cyc++) begin
      @(negedge clk);
      if (fire_i) ti++;
      if (ti < NV)
        drive(1'b1, VEC[ti][34:27], VEC[ti][26:24], VEC[ti][7:0], VEC[ti][15:8], VEC[ti][23:16]);
      else
        drive(1'b0, 8'h00, 3'b000, 8'd0, 8'd0, 8'd0);
      dsp_ready = (cyc % 3) != 1;
      #1;
      fire_i = iss_valid && iss_ready;
      if (dsp_valid && dsp_ready) begin
        chk_dsp("R8/R6/R7 table", VEC[ri][34:27], VEC[ri][26:24],
                VEC[ri][7:0], VEC[ri][15:8], VEC[ri][23:16]);
        ri++;
      end
    end
    chk("R8 all dispatched", ri, NV);

    // arbitration: A = {0,4,8} all bank 0, B = {12,1} banks 0 and 1
    @(negedge clk);
    dsp_ready = 1'b0;
    drive(1'b1, 8'hA0, 3'b111, 8'd0, 8'd4, 8'd8);
    @(negedge clk);
    drive(1'b1, 8'hB0, 3'b011, 8'd12, 8'd1, 8'd0);
    #1;
    chk("R3 first grant req",   {28'd0, rd_req}, 32'h1);
    chk("R4 A src0 addr",       {24'd0, rd_addr[7:0]}, 32'd0);
    @(negedge clk);
    drive(1'b0, 8'h00, 3'b000, 8'd0, 8'd0, 8'd0);
    #1;
    chk("R5 greedy req",        {28'd0, rd_req}, 32'h3);
    chk("R4 A src1 over B",     {24'd0, rd_addr[7:0]}, 32'd4);
    chk("R5 B bank1 addr",      {24'd0, rd_addr[15:8]}, 32'd1);
    @(negedge clk); #1;
    chk("R4 A src2 req",        {28'd0, rd_req}, 32'h1);
    chk("R4 A src2 addr",       {24'd0, rd_addr[7:0]}, 32'd8);
    chk("R8 A not ready yet",   {31'd0, dsp_valid}, 32'd0);
    @(negedge clk); #1;
    chk("R4 B src0 req",        {28'd0, rd_req}, 32'h1);
    chk("R2 B src0 addr",       {24'd0, rd_addr[7:0]}, 32'd12);
    chk("R8 A not ready yet",   {31'd0, dsp_valid}, 32'd0);
    @(negedge clk); #1;
    chk("R3 no more reqs",      {28'd0, rd_req}, 32'h0);
    chk("R8 A valid timing",    {31'd0, dsp_valid}, 32'd1);
    chk_dsp("R6 A", 8'hA0, 3'b111, 8'd0, 8'd4, 8'd8);
    @(negedge clk); #1;
    chk("R8 A held",            {31'd0, dsp_valid}, 32'd1);
    chk("R8 A held tag",        {24'd0, dsp_tag}, 32'hA0);
    dsp_ready = 1'b1;
    @(negedge clk); #1;
    chk("R8 B next",            {31'd0, dsp_valid}, 32'd1);
    chk_dsp("R7 B", 8'hB0, 3'b011, 8'd12, 8'd1, 8'd0);
    @(negedge clk); #1;
    chk("R8 drained",           {31'd0, dsp_valid}, 32'd0);

    // back-pressure
    dsp_ready = 1'b0;
    for (int n = 0; n < 4; n++) begin
      drive(1'b1, 8'h20 + 8'(n), 3'b000, 8'd0, 8'd0, 8'd0);
      #1;
      chk("R9 accept while room", {31'd0, iss_ready}, 32'd1);
      @(negedge clk);
    end
    drive(1'b1, 8'h99, 3'b000, 8'd0, 8'd0, 8'd0);
    #1;
    chk("R9 full stall", {31'd0, iss_ready}, 32'd0);
    @(negedge clk);
    dsp_ready = 1'b1;
    drive(1'b1, 8'h24, 3'b000, 8'd0, 8'd0, 8'd0);
    #1;
    chk("R9 full with dispatch", {31'd0, iss_ready}, 32'd1);
    chk("R8 head tag 20",        {24'd0, dsp_tag}, 32'h20);
    @(negedge clk);
    drive(1'b0, 8'h00, 3'b000, 8'd0, 8'd0, 8'd0);
    for (int n = 1; n < 5; n++) begin
      #1;
      chk("R9 drain valid", {31'd0, dsp_valid}, 32'd1);
      chk("R9 drain order, dropped issue absent", {24'd0, dsp_tag}, 32'h20 + n);
      @(negedge clk);
    end
    #1;
    chk("R9 empty after drain", {31'd0, dsp_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule